// File: doc/BRIEF.md
# Memory-Line Atomic Read-Modify-Write Unit

This block performs one indivisible read-modify-write request at a time against a local memory built from 128-bit lines. A request carries three operands: a 32-bit byte address, a 16-bit parameter word and a 32-bit data operand. The parameter word holds the opcode and the operation's packed arguments. The unit reads the 16-byte line that holds the address (address with its low four bits cleared) and computes the updated line. It writes the line back and then reports the 32-bit word that was at the target address before the update.

Five updates are supported: a plain increment, an increment that wraps modulo a small bound, a compare-and-swap on the low half of a chosen word, a swap of selected 16-bit granules, and a full 32-bit swap of a chosen word. A response-requested flag with each request decides whether the old word is returned on the response port. A single-cycle done pulse marks the end of every request. The local memory is cleared by reset. It can be inspected through the normal request port, because a no-op request still returns the addressed word.

Top module: `mem_atomic_unit`

## Requirements
- R1: The opcode is parameter bits [15:12]. 0x0 is a no-op, 0x1 is increment, 0x2 is wrapping increment, 0x3 is masked granule swap, 0x4 is compare-and-swap and 0x7 is full word swap. A no-op leaves memory unchanged.
- R2: Both increments add the amount in parameter bits [9:6], where 0 stands for 1, to the word at the target address, modulo 2^32. The plain increment ignores bits [5:2].
- R3: The wrapping increment takes its bound from parameter bits [5:2]. A bound of 0 means no wrap. Otherwise, when old value plus amount (computed without truncation) is at least the bound, the stored value is 0.
- R4: Compare-and-swap selects word (address & ~0xF) + 4*param[3:2]. If the word's low 16 bits equal data[15:0], those 16 bits become data[31:16]. The upper 16 bits never change.
- R5: The masked swap uses mask parameter bits [11:4]. When mask bit i is set, 16-bit granule i of the line (byte offset 2*i) is written: even granules take data[15:0] and odd granules take data[31:16]. Granules with a clear mask bit keep their value.
- R6: The full swap writes all 32 data bits to word (address & ~0xF) + 4*param[3:2].
- R7: The returned word is the one at (address & ~0x3) as it was before the write-back, whatever word the operation modifies.
- R8: `resp_valid` is high together with `done` only when the request's `req_resp` flag was set. `resp_data` is 0 whenever `resp_valid` is low.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` stays low until `done`. `done` rises exactly three clock edges after acceptance and lasts one cycle.
- R10: Opcodes 0x5, 0x6 and 0x8 to 0xF leave memory unchanged and raise `err` during the `done` cycle.
- R11: After reset every memory line is zero, `req_ready` is high, and `done`, `err` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Target byte address |
| req_param | input | 16 | Opcode and packed operation arguments |
| req_data | input | 32 | Data operand |
| req_resp | input | 1 | Return the old word on completion |
| req_ready | output | 1 | Unit idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| resp_valid | output | 1 | Response word valid (with done) |
| resp_data | output | 32 | Old word at the target address |
| err | output | 1 | Unlisted opcode (with done) |

## Verification
The increment amount field is swept over all 16 values while junk sits in the wrap field, which separates a correct 0-means-1 rule from a design that honours the wrap bits on the plain increment. All 16 wrap bounds are applied to starting values just below, at and above the bound, and to the all-ones word, which separates ≥ from > and 33-bit from truncated sums. All 256 granule masks are tried on a line with distinct granules, and compare-and-swap is tried as a hit and a miss at every offset with the target word chosen apart from the modified word, which separates the returned word from the written one. Every request is followed by no-op reads of the line, so a stray write to any neighbouring word is visible.

// File: rtl/mau_pkg.sv
// Shared constants and types for the memory-line atomic unit.
// Assumes a 128-bit line split into four 32-bit words and eight 16-bit granules.
package mau_pkg;
    localparam int WORD_W     = 32;
    localparam int GRAN_W     = 16;
    localparam int N_WORD     = 4;
    localparam int N_GRAN     = 8;
    localparam int LINE_W     = WORD_W * N_WORD;
    localparam int LINE_BYTES = LINE_W / 8;
    localparam int OFS_BITS   = $clog2(LINE_BYTES);

    typedef enum logic [3:0] {
        OP_NOP      = 4'h0,
        OP_INC      = 4'h1,
        OP_INC_WRAP = 4'h2,
        OP_GSWAP    = 4'h3,
        OP_CAS      = 4'h4,
        OP_SWAP32   = 4'h7
    } op_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] param;
        logic [31:0] data;
        logic        resp;
    } req_t;
endpackage

// File: rtl/mau_line_mem.sv
// Line-wide SRAM model: one registered read port and one write port.
// Assumes reads and writes never target the same line in the same cycle,
// which the controller guarantees by its phase ordering. Reset clears all lines.
module mau_line_mem #(
    parameter int LINES  = 16,
    parameter int LINE_W = 128,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] store [LINES];

    // Clear on reset; otherwise perform the requested write and registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                store[i] <= '0;
            end
            rd_line <= '0;
        end else begin
            if (wr_en) begin
                store[wr_idx] <= wr_line;
            end
            if (rd_en) begin
                rd_line <= store[rd_idx];
            end
        end
    end
endmodule

// File: rtl/mau_op_alu.sv
// Combinational update engine: given the old line and a request, produces the
// new line, whether it must be written, the old target word and an opcode error.
// Assumes the line is little-endian: word k at bits [32k+31:32k], granule g at [16g+15:16g].
module mau_op_alu
    import mau_pkg::*;
(
    input  logic [LINE_W-1:0] line_in,
    input  logic [15:0]       param,
    input  logic [31:0]       data,
    input  logic [1:0]        tgt_word,
    output logic [LINE_W-1:0] line_out,
    output logic              wr_req,
    output logic [31:0]       orig_word,
    output logic              bad_op
);
    logic [N_WORD-1:0][WORD_W-1:0] words_in;
    logic [N_WORD-1:0][WORD_W-1:0] words_out;
    logic [N_GRAN-1:0][GRAN_W-1:0] gran_in;
    logic [N_GRAN-1:0][GRAN_W-1:0] gran_sw;
    logic [3:0]  opcode;
    logic [3:0]  amt_raw;
    logic [3:0]  bound;
    logic [1:0]  sel_word;
    logic [7:0]  gmask;
    logic [31:0] incr;
    logic [32:0] sum_full;
    logic [31:0] inc_result;
    logic        cas_hit;

    assign words_in = line_in;
    assign gran_in  = line_in;
    assign opcode   = param[15:12];
    assign amt_raw  = param[9:6];
    assign bound    = param[5:2];
    assign sel_word = param[3:2];
    assign gmask    = param[11:4];

    assign orig_word = words_in[tgt_word];

    // Increment amount with the zero-means-one rule.
    always_comb begin
        incr = {28'd0, amt_raw};
        if (amt_raw == 4'd0) begin
            incr = 32'd1;
        end
    end

    assign sum_full = {1'b0, orig_word} + {1'b0, incr};

    // Apply the wrap bound only for the wrapping opcode with a non-zero bound.
    always_comb begin
        inc_result = sum_full[31:0];
        if (opcode == OP_INC_WRAP && bound != 4'd0 && sum_full >= {29'd0, bound}) begin
            inc_result = '0;
        end
    end

    assign cas_hit = (words_in[sel_word][15:0] == data[15:0]);

    // Per-granule write selection for the masked swap.
    for (genvar g = 0; g < N_GRAN; g++) begin : g_gran
        if (g % 2 == 0) begin : g_even
            assign gran_sw[g] = gmask[g] ? data[15:0] : gran_in[g];
        end else begin : g_odd
            assign gran_sw[g] = gmask[g] ? data[31:16] : gran_in[g];
        end
    end

    // Build the updated line and the write request for each opcode.
    always_comb begin
        words_out = words_in;
        wr_req    = 1'b0;
        bad_op    = 1'b0;
        unique case (opcode)
            OP_NOP: begin
                wr_req = 1'b0;
            end
            OP_INC, OP_INC_WRAP: begin
                words_out[tgt_word] = inc_result;
                wr_req              = 1'b1;
            end
            OP_GSWAP: begin
                words_out = gran_sw;
                wr_req    = 1'b1;
            end
            OP_CAS: begin
                if (cas_hit) begin
                    words_out[sel_word][15:0] = data[31:16];
                end
                wr_req = 1'b1;
            end
            OP_SWAP32: begin
                words_out[sel_word] = data;
                wr_req              = 1'b1;
            end
            default: begin
                bad_op = 1'b1;
            end
        endcase
    end

    assign line_out = words_out;
endmodule

// File: rtl/mau_ctrl.sv
// Sequencer: accepts one request, steps it through a read phase and a
// modify/write phase, then issues the one-cycle done pulse with the response.
// Assumes the memory read is registered (one cycle) and the update is combinational.
module mau_ctrl
    import mau_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  req_t        req_in,
    output logic        req_ready,
    output req_t        req_q,
    output logic        rd_en,
    output logic        wr_phase,
    input  logic [31:0] alu_orig,
    input  logic        alu_err,
    output logic        done,
    output logic        resp_valid,
    output logic [31:0] resp_data,
    output logic        err
);
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MODIFY} state_e;
    state_e state;

    assign req_ready = (state == ST_IDLE);
    assign rd_en     = (state == ST_READ);
    assign wr_phase  = (state == ST_MODIFY);

    // Phase sequencing, request capture and completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            req_q      <= '0;
            done       <= 1'b0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
            err        <= 1'b0;
        end else begin
            done       <= 1'b0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
            err        <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    state <= ST_MODIFY;
                end
                ST_MODIFY: begin
                    state      <= ST_IDLE;
                    done       <= 1'b1;
                    err        <= alu_err;
                    resp_valid <= req_q.resp;
                    resp_data  <= req_q.resp ? alu_orig : '0;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/mem_atomic_unit.sv
// Top of the memory-line atomic unit: ties the sequencer, the line memory and
// the update engine together. Assumes line index = address bits above the
// 16-byte offset, truncated to the memory depth.
module mem_atomic_unit #(
    parameter int LINES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [15:0] req_param,
    input  logic [31:0] req_data,
    input  logic        req_resp,
    output logic        req_ready,
    output logic        done,
    output logic        resp_valid,
    output logic [31:0] resp_data,
    output logic        err
);
    import mau_pkg::*;

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    req_t              req_in;
    req_t              req_q;
    logic              rd_en;
    logic              wr_phase;
    logic [LINE_W-1:0] line_rd;
    logic [LINE_W-1:0] line_new;
    logic              alu_wr;
    logic [31:0]       alu_orig;
    logic              alu_err;
    logic [IDX_W-1:0]  line_idx;

    assign req_in = '{addr: req_addr, param: req_param, data: req_data, resp: req_resp};

    if (LINES > 1) begin : g_idx
        assign line_idx = req_q.addr[OFS_BITS +: IDX_W];
    end else begin : g_idx1
        assign line_idx = 1'b0;
    end

    mau_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_in     (req_in),
        .req_ready  (req_ready),
        .req_q      (req_q),
        .rd_en      (rd_en),
        .wr_phase   (wr_phase),
        .alu_orig   (alu_orig),
        .alu_err    (alu_err),
        .done       (done),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .err        (err)
    );

    mau_line_mem #(.LINES(LINES), .LINE_W(LINE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_idx  (line_idx),
        .rd_line (line_rd),
        .wr_en   (wr_phase && alu_wr),
        .wr_idx  (line_idx),
        .wr_line (line_new)
    );

    mau_op_alu u_alu (
        .line_in   (line_rd),
        .param     (req_q.param),
        .data      (req_q.data),
        .tgt_word  (req_q.addr[3:2]),
        .line_out  (line_new),
        .wr_req    (alu_wr),
        .orig_word (alu_orig),
        .bad_op    (alu_err)
    );
endmodule

// File: rtl/mau_checker.sv
// Protocol checker for the atomic unit's handshake and response outputs.
// Assumes it is bound to mem_atomic_unit and sees its ports only.
module mau_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic        resp_valid,
    input logic [31:0] resp_data,
    input logic        err
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                          // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                 // R9
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);                                      // R9
    AST_RESP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> done);                                     // R8
    AST_RESP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (resp_data == 32'd0));                    // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);                                            // R10
endmodule

bind mem_atomic_unit mau_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done       (done),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .err        (err)
);

// File: tb/tb_mem_atomic_unit.sv
// Self-checking bench: drives requests, keeps its own line model and
// compares returned words, handshake timing and error flags.
module tb_mem_atomic_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_param = '0;
    logic [31:0] req_data = '0;
    logic        req_resp = 1'b0;
    logic        req_ready;
    logic        done;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        err;

    int n_checks = 0;
    int n_errors = 0;
    logic [127:0] mdl [16];

    always #10 clk = ~clk;   // 50 MHz

    mem_atomic_unit #(.LINES(16)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_param(req_param), .req_data(req_data), .req_resp(req_resp),
        .req_ready(req_ready), .done(done), .resp_valid(resp_valid),
        .resp_data(resp_data), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference update; returns the old target word.
    task automatic model(input logic [31:0] a, input logic [15:0] p, input logic [31:0] d,
                         output logic [31:0] old);
        int idx = int'(a[7:4]);
        int w = int'(a[3:2]);
        int o = int'(p[3:2]);
        longint unsigned s;
        longint unsigned amt;
        old = mdl[idx][w*32 +: 32];
        case (p[15:12])
            4'h1, 4'h2: begin
                amt = (p[9:6] == 0) ? 1 : longint'(p[9:6]);
                s = longint'(old) + amt;
                if (p[15:12] == 4'h2 && p[5:2] != 0 && s >= longint'(p[5:2])) s = 0;
                mdl[idx][w*32 +: 32] = s[31:0];
            end
            4'h3: for (int i = 0; i < 8; i++)
                if (p[4+i]) mdl[idx][i*16 +: 16] = (i % 2 == 1) ? d[31:16] : d[15:0];
            4'h4: if (mdl[idx][o*32 +: 16] == d[15:0]) mdl[idx][o*32 +: 16] = d[31:16];
            4'h7: mdl[idx][o*32 +: 32] = d;
            default: ;
        endcase
    endtask

    // Issue one request, check latency, busy handshake, response and error.
    task automatic run(input logic [31:0] a, input logic [15:0] p, input logic [31:0] d,
                       input bit r, input string tag);
        logic [31:0] old;
        bit bad;
        int lat;
        model(a, p, d, old);
        bad = !(p[15:12] inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h7});
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_param = p; req_data = d; req_resp = r;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            if (req_ready) chk(1'b0, "R9 ready while busy", 32'd1, 32'd0);
            @(negedge clk);
            lat++;
        end
        if (lat >= 20) begin
            chk(1'b0, "R9 watchdog", 32'(lat), 32'd3);
        end else begin
            chk(lat == 3, "R9 latency", 32'(lat), 32'd3);
            chk(resp_valid == r, {"R8 resp_valid ", tag}, 32'(resp_valid), 32'(r));
            chk(resp_data == (r ? old : 32'd0), {"R7 ", tag}, resp_data, r ? old : 32'd0);
            chk(err == bad, {"R10 err ", tag}, 32'(err), 32'(bad));
        end
    endtask

    // Read all four words of a line through no-op requests.
    task automatic verify_line(input int idx, input string tag);
        for (int w = 0; w < 4; w++) run(32'(idx*16 + w*4), 16'h0000, 32'hDEAD_BEEF, 1'b1, {"R1 ", tag});
    endtask

    task automatic fill_line(input int idx, input logic [127:0] v);
        for (int w = 0; w < 4; w++) run(32'(idx*16), {4'h7, 8'h00, 2'(w), 2'b00}, v[w*32 +: 32], 1'b0, "R6 fill");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk(done == 0 && err == 0 && resp_valid == 0, "R11 outputs idle", {29'd0, done, err, resp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'd1);
        for (int i = 0; i < 4; i++) verify_line(i, "reset zero R11");

        // R2: all amounts, junk in the wrap field, response off on odd steps
        for (int k = 0; k < 16; k++)
            run(32'h10 + 32'((k % 4) * 4), {4'h1, 2'b00, 4'(k), 4'(15 - k), 2'b01}, 32'h0, (k % 2) == 0, "R2 inc");
        verify_line(1, "R2 after");
        fill_line(2, {32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF});
        run(32'h20, {4'h1, 2'b00, 4'd1, 4'd3, 2'b00}, 32'h0, 1'b1, "R2 rollover");
        verify_line(2, "R2 rollover");

        // R3: every bound, start values around the bound
        for (int b = 0; b < 16; b++) begin
            for (int st = b - 2; st <= b + 1; st++) begin
                if (st < 0) continue;
                run(32'h34, {4'h7, 8'h00, 2'd1, 2'b00}, 32'(st), 1'b0, "R3 preset");
                run(32'h34, {4'h2, 2'b00, 4'((b % 3) + 1), 4'(b), 2'b00}, 32'h0, 1'b1, "R3 wrap");
                run(32'h34, 16'h0000, 32'h0, 1'b1, "R3 readback");
            end
        end
        run(32'h34, {4'h7, 8'h00, 2'd1, 2'b00}, 32'hFFFF_FFFF, 1'b0, "R3 preset");
        run(32'h34, {4'h2, 2'b00, 4'd2, 4'd5, 2'b00}, 32'h0, 1'b1, "R3 overflow");
        run(32'h34, 16'h0000, 32'h0, 1'b1, "R3 readback");

        // R4: hit and miss at every offset, target word differs from offset
        for (int o = 0; o < 4; o++) begin
            fill_line(4, {32'hA3A3_0333, 32'hA2A2_0222, 32'hA1A1_0111, 32'hA0A0_0000});
            run(32'h40 + 32'(((o + 1) % 4) * 4), {4'h4, 8'h00, 2'(o), 2'b00},
                {16'h5A5A, 16'(o * 16'h0111)}, 1'b1, "R4 hit");
            verify_line(4, "R4 hit");
            run(32'h40 + 32'(((o + 2) % 4) * 4), {4'h4, 8'h00, 2'(o), 2'b00},
                {16'h7777, 16'h1234}, 1'b1, "R4 miss");
            verify_line(4, "R4 miss");
        end

        // R5: every mask
        for (int m = 0; m < 256; m++) begin
            fill_line(5, {32'h7766_5544, 32'h3322_1100, 32'hF0E0_D0C0, 32'hB0A0_9080});
            run(32'h50 + 32'((m % 4) * 4), {4'h3, 8'(m), 4'h0}, 32'hCAFE_BEAD, 1'b1, "R5 mask");
            verify_line(5, "R5 mask");
        end

        // R6: every offset
        for (int o = 0; o < 4; o++) begin
            run(32'h60 + 32'(((3 - o)) * 4), {4'h7, 8'h00, 2'(o), 2'b00}, 32'h1357_9BD0 + 32'(o), 1'b1, "R6 swap");
            verify_line(6, "R6 swap");
        end

        // R10: unlisted opcodes leave memory unchanged
        fill_line(7, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
        for (int op = 5; op < 16; op++) begin
            if (op == 7) continue;
            run(32'h74, {4'(op), 12'hFFF}, 32'h0BAD_0BAD, 1'b1, "R10 bad op");
            verify_line(7, "R10 unchanged");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Global watchdog: counts as a failed check and still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R9 watchdog expired: got %0d expected %0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule